// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does so by reading a two-level translation table that lives in ordinary memory. A client presents one linear address at a time on a request/acknowledge port. The walker then fetches the directory entry and, if that entry is marked present, the table entry. It answers with either a physical address or a fault. A fault report says which level failed and which linear address caused it.

The directory sits in a single 4 KB page. The frame of that page is held in a loadable base register. Loading a new value switches the walker to another address space. This is how a context switch of the owning process is modelled. All reads go through a simple word-read port. The port has a one-cycle read strobe and a response-valid input, and the memory may answer after any number of cycles.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `fault` and `mem_rd` are all low.
- R2: `ack` is high in a cycle only when `req` is high and the walker is idle. The request is accepted at that clock edge, and `busy` is high from the next cycle until the cycle in which `done` or `fault` pulses. While `busy` is high, `ack` stays low whatever `req` does.
- R3: The first read of every walk uses the address {base[31:12], la[31:22], 2'b00}. Here base is the last loaded base value and la is the accepted linear address.
- R4: The second read uses the address {dentry[31:12], la[21:12], 2'b00}, where dentry is the word returned by the first read. Bits 11:0 of dentry play no part in that address.
- R5: When both entries have bit 0 set, `done` pulses and `pa` equals {tentry[31:12], la[11:0]}, where tentry is the word returned by the second read. Bits 11:1 of tentry do not reach `pa`.
- R6: A directory entry with bit 0 clear ends the walk after exactly one read. `fault` pulses with `fault_lvl` = 0 and `fault_la` = la.
- R7: A table entry with bit 0 clear ends the walk after exactly two reads. `fault` pulses with `fault_lvl` = 1 and `fault_la` = la.
- R8: `mem_rd` is a one-cycle pulse, and no new read is issued before the previous one has been answered. The walker waits for `mem_rvalid` however late it comes. A `mem_rvalid` pulse while no read is outstanding is ignored.
- R9: A `base_ld` pulse captures `base_val`, ignoring its bits 11:0. The new base applies to every request accepted in that same cycle or later.
- R10: `done` and `fault` are never high together, and each is high for a single cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_ld | input | 1 | Load strobe for the directory base |
| base_val | input | 32 | New directory base (bits 31:12 kept) |
| req | input | 1 | Translation request |
| req_la | input | 32 | Linear address to translate |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: `pa` valid |
| pa | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle pulse: walk aborted |
| fault_lvl | output | 1 | 0 = directory entry absent, 1 = table entry absent |
| fault_la | output | 32 | Linear address that faulted |
| mem_rd | output | 1 | Word read strobe |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench fills entries with junk in their flag bits. A design that let those bits leak into a frame would read from the wrong place or return a wrong `pa`. The indices are pushed to all-ones, to catch a shift or slice that is off by one. The bench also records the exact address of every read, which exposes a swapped directory/table index or a missing scale by four.

Faults are forced at both levels, and the number of reads per walk is counted. A walker that still fetched a table entry after an absent directory entry would show up, as would one that reported the wrong level. The bench varies the memory latency and injects a stray response while the walker is idle. A design that sampled data without waiting, or that acted on an unrequested response, would return wrong results. The base is reloaded with non-zero low bits and then restored, which exposes a stale or mis-masked base.

// File: rtl/pgwalk_pkg.sv
// Package: shared types and constants of the two-level walker.
// Assumes entries keep their present flag in bit 0 at both levels.
package pgwalk_pkg;
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR_REQ,
        WS_DIR_WAIT,
        WS_TBL_REQ,
        WS_TBL_WAIT
    } walk_state_e;

    localparam int  PRES_BIT = 0;
    localparam logic LVL_DIR = 1'b0;
    localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/pgwalk_basereg.sv
// Directory base register: holds the page-aligned frame of the active
// directory. Assumes the caller passes only the frame bits of the new base.
module pgwalk_basereg #(
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [FRAME_W-1:0] ld_frame,
    output logic [FRAME_W-1:0] frame
);
    // capture a new frame on each load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)  frame <= '0;
        else if (ld) frame <= ld_frame;
    end
endmodule

// File: rtl/pgwalk_addrgen.sv
// Entry address former: joins a table frame with a scaled index to give the
// word address of a directory or table entry. Assumes 4-byte entries, so
// the index width plus two equals the page offset width.
module pgwalk_addrgen #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic                   sel_tbl,
    input  logic [AW-OFF_W-1:0]    dir_frame,
    input  logic [AW-OFF_W-1:0]    tbl_frame,
    input  logic [OFF_W-3:0]       dir_idx,
    input  logic [OFF_W-3:0]       tbl_idx,
    output logic [AW-1:0]          ent_addr
);
    // choose the level and scale the index by the entry size
    always_comb begin
        if (sel_tbl) ent_addr = {tbl_frame, tbl_idx, 2'b00};
        else         ent_addr = {dir_frame, dir_idx, 2'b00};
    end
endmodule

// File: rtl/pgwalk_seq.sv
// Walk sequencer: accepts one request, issues the directory read and then
// the table read, checks the present flag of each entry and produces a
// one-cycle done or fault pulse. Assumes memory answers each read exactly
// once, at any latency.
module pgwalk_seq
    import pgwalk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [AW-1:0]       req_la,
    output logic                ack,
    output logic                busy,
    output logic                mem_rd,
    output logic                sel_tbl,
    input  logic                mem_rvalid,
    input  logic [AW-1:0]       mem_rdata,
    output logic [AW-1:0]       la_q,
    output logic [AW-OFF_W-1:0] tbl_frame_q,
    output logic                done,
    output logic [AW-1:0]       pa,
    output logic                fault,
    output logic                fault_lvl,
    output logic [AW-1:0]       fault_la
);
    walk_state_e state;
    logic        present;
    logic        unused_flag_bits;

    assign present          = mem_rdata[PRES_BIT];
    assign unused_flag_bits = ^mem_rdata[OFF_W-1:PRES_BIT+1];

    // handshake and read strobe decoded from the walk state
    always_comb begin
        ack     = req && (state == WS_IDLE);
        busy    = (state != WS_IDLE);
        mem_rd  = (state == WS_DIR_REQ) || (state == WS_TBL_REQ);
        sel_tbl = (state == WS_TBL_REQ);
    end

    // walk state, captured entry frame and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            la_q        <= '0;
            tbl_frame_q <= '0;
            done        <= 1'b0;
            pa          <= '0;
            fault       <= 1'b0;
            fault_lvl   <= LVL_DIR;
            fault_la    <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req) begin
                        la_q  <= req_la;
                        state <= WS_DIR_REQ;
                    end
                end
                WS_DIR_REQ: state <= WS_DIR_WAIT;
                WS_DIR_WAIT: begin
                    if (mem_rvalid) begin
                        if (present) begin
                            tbl_frame_q <= mem_rdata[AW-1:OFF_W];
                            state       <= WS_TBL_REQ;
                        end else begin
                            fault     <= 1'b1;
                            fault_lvl <= LVL_DIR;
                            fault_la  <= la_q;
                            state     <= WS_IDLE;
                        end
                    end
                end
                WS_TBL_REQ: state <= WS_TBL_WAIT;
                WS_TBL_WAIT: begin
                    if (mem_rvalid) begin
                        if (present) begin
                            pa   <= {mem_rdata[AW-1:OFF_W], la_q[OFF_W-1:0]};
                            done <= 1'b1;
                        end else begin
                            fault     <= 1'b1;
                            fault_lvl <= LVL_TBL;
                            fault_la  <= la_q;
                        end
                        state <= WS_IDLE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault); // R10
    AST_RD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R8
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack); // R2
    AST_ACK_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> busy); // R2
    AST_DONE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pa[OFF_W-1:0] == la_q[OFF_W-1:0])); // R5
    AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy); // R2
endmodule

// File: rtl/pgwalk_top.sv
// Two-level translation walker top: wires the base register, entry address
// former and walk sequencer to the request and memory ports. Assumes
// AW == OFF_W + 2*(OFF_W-2), i.e. two index fields of equal width.
module pgwalk_top #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_ld,
    input  logic [AW-1:0] base_val,
    input  logic          req,
    input  logic [AW-1:0] req_la,
    output logic          ack,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pa,
    output logic          fault,
    output logic          fault_lvl,
    output logic [AW-1:0] fault_la,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata
);
    localparam int FRAME_W = AW - OFF_W;
    localparam int IDX_W   = OFF_W - 2;

    logic [FRAME_W-1:0] dir_frame;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [AW-1:0]      la_q;
    logic               sel_tbl;
    logic               unused_base_low;

    assign unused_base_low = ^base_val[OFF_W-1:0];

    pgwalk_basereg #(.FRAME_W(FRAME_W)) i_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (base_ld),
        .ld_frame (base_val[AW-1:OFF_W]),
        .frame    (dir_frame)
    );

    pgwalk_addrgen #(.AW(AW), .OFF_W(OFF_W)) i_addr (
        .sel_tbl   (sel_tbl),
        .dir_frame (dir_frame),
        .tbl_frame (tbl_frame_q),
        .dir_idx   (la_q[AW-1 -: IDX_W]),
        .tbl_idx   (la_q[OFF_W +: IDX_W]),
        .ent_addr  (mem_addr)
    );

    pgwalk_seq #(.AW(AW), .OFF_W(OFF_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_la      (req_la),
        .ack         (ack),
        .busy        (busy),
        .mem_rd      (mem_rd),
        .sel_tbl     (sel_tbl),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .la_q        (la_q),
        .tbl_frame_q (tbl_frame_q),
        .done        (done),
        .pa          (pa),
        .fault       (fault),
        .fault_lvl   (fault_lvl),
        .fault_la    (fault_la)
    );

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy); // R8
endmodule

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_ld = 1'b0;
    logic [31:0] base_val = '0;
    logic        req = 1'b0;
    logic [31:0] req_la = '0;
    logic        ack, busy, done, fault, fault_lvl, mem_rd;
    logic [31:0] pa, fault_la, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_val(base_val),
        .req(req), .req_la(req_la), .ack(ack), .busy(busy), .done(done),
        .pa(pa), .fault(fault), .fault_lvl(fault_lvl), .fault_la(fault_la),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic [31:0] la;
        bit          is_fault;
        bit          lvl;
        logic [31:0] pa;
        int          nreads;
        logic [31:0] a0;
        logic [31:0] a1;
        string       rq;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        sb[$];
    logic [31:0] iss[$];
    logic [31:0] tb_base = '0;
    int          lat = 1;
    int          nchk = 0;
    int          nfail = 0;
    bit          stray_go = 1'b0;
    bit          prev_out = 1'b0;

    function automatic logic [31:0] rd_model(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // memory responder: one outstanding read, fixed latency, optional stray pulse
    int          cnt = 0;
    bit          pend = 1'b0;
    logic [31:0] paddr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            cnt--;
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_model(paddr);
                pend       = 1'b0;
            end
        end else if (rst_n && mem_rd) begin
            paddr = mem_addr;
            iss.push_back(mem_addr);
            pend = 1'b1;
            cnt  = lat;
        end else if (stray_go) begin
            mem_rvalid = 1'b1;
            mem_rdata  = 32'hFFFF_FFFF;
            stray_go   = 1'b0;
        end
    end

    // monitor: pop expected results and compare them with what came out
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_out)
                chk(!done && !fault, "R10", "pulse longer than one cycle", {30'b0, done, fault}, 32'h0);
            if (done || fault) begin
                exp_t e;
                chk(!(done && fault), "R10", "done and fault together", {30'b0, done, fault}, 32'h0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected result", pa, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(fault == e.is_fault, e.rq, "outcome kind", {31'b0, fault}, {31'b0, e.is_fault});
                    if (e.is_fault) begin
                        chk(fault_lvl == e.lvl, e.rq, "fault level", {31'b0, fault_lvl}, {31'b0, e.lvl});
                        chk(fault_la == e.la, e.rq, "fault address", fault_la, e.la);
                    end else begin
                        chk(pa == e.pa, e.rq, "physical address", pa, e.pa);
                    end
                    chk(iss.size() == e.nreads, "R8", "read count", iss.size(), e.nreads);
                    if (iss.size() > 0)
                        chk(iss[0] == e.a0, "R3", "directory entry address", iss[0], e.a0);
                    if (iss.size() > 1 && e.nreads > 1)
                        chk(iss[1] == e.a1, "R4", "table entry address", iss[1], e.a1);
                end
                iss.delete();
            end
            prev_out = done || fault;
        end
    end

    // driver: compute the expected outcome, push it, then hand the request over
    task automatic xlate(logic [31:0] la);
        exp_t e;
        logic [31:0] de, te;
        bit held_off;
        e.la = la;
        e.a0 = {tb_base[31:12], la[31:22], 2'b00};
        de   = rd_model(e.a0);
        e.a1 = {de[31:12], la[21:12], 2'b00};
        te   = rd_model(e.a1);
        e.pa = '0;
        e.lvl = 1'b0;
        if (!de[0]) begin
            e.is_fault = 1'b1; e.lvl = 1'b0; e.nreads = 1; e.rq = "R6";
        end else if (!te[0]) begin
            e.is_fault = 1'b1; e.lvl = 1'b1; e.nreads = 2; e.rq = "R7";
        end else begin
            e.is_fault = 1'b0; e.nreads = 2; e.rq = "R5";
            e.pa = {te[31:12], la[11:0]};
        end
        sb.push_back(e);
        held_off = 1'b1;
        @(negedge clk);
        req = 1'b1;
        req_la = la;
        #1;
        while (!ack) begin
            if (!busy) held_off = 1'b0;
            @(negedge clk);
            #1;
        end
        chk(held_off, "R2", "ack while busy", 32'h1, 32'h0);
        @(negedge clk);
        req = 1'b0;
        req_la = 32'hFFFF_FFFF;
        chk(busy, "R2", "busy after accept", {31'b0, busy}, 32'h1);
    endtask

    task automatic drain();
        int n = 0;
        while ((sb.size() != 0 || busy) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(sb.size() == 0, "R8", "results outstanding", sb.size(), 32'h0);
    endtask

    task automatic load_base(logic [31:0] v);
        @(negedge clk);
        base_ld = 1'b1;
        base_val = v;
        @(negedge clk);
        base_ld = 1'b0;
        base_val = 32'h0;
        tb_base = v;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        chk(1'b0, "R8", "watchdog expired", 32'h0, 32'h0);
        report();
    end

    initial begin
        // directory A at 0x00010000, directory B at 0x00050000
        mem[32'h0001_0004] = 32'h0002_0FFF;   // present, all flag bits set
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0002_0004] = 32'h1234_5001;
        mem[32'h0002_0008] = 32'h5555_5FFE;   // not present, flags set
        mem[32'h0003_0FFC] = 32'hABCD_E003;
        mem[32'h0005_0004] = 32'h0006_0001;
        mem[32'h0006_0004] = 32'h7777_7001;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_rd, "R1", "outputs during reset",
            {28'b0, busy, done, fault, mem_rd}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_rd, "R1", "outputs after reset",
            {28'b0, busy, done, fault, mem_rd}, 32'h0);

        // R9: low base bits must be ignored
        load_base(32'h0001_0ABC);
        lat = 1;
        xlate(32'h0040_1234);   // R5 success, flag bits in directory entry
        xlate(32'hFFFF_FFFC);   // R3 R4 all-ones indices
        xlate(32'h0000_0000);   // R6 directory fault
        xlate(32'h0040_2000);   // R7 table fault
        drain();

        lat = 4;
        xlate(32'h0040_1FFF);
        xlate(32'h0000_0ABC);
        drain();

        // R8: a stray response while idle must not disturb the next walk
        @(negedge clk);
        stray_go = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !fault && !busy, "R8", "stray response acted on",
            {29'b0, done, fault, busy}, 32'h0);
        lat = 7;
        xlate(32'h0040_1234);
        drain();

        // R9: switch address space, then switch back
        load_base(32'h0005_0FFF);
        lat = 2;
        xlate(32'h0040_1234);   // maps to 0x77777234
        xlate(32'h0080_0000);   // R6 absent in directory B
        drain();
        load_base(32'h0001_0000);
        xlate(32'h0040_1234);
        drain();

        repeat (5) @(negedge clk);
        report();
    end
endmodule